// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A. It is the feedback divider of one synthesizer channel. A dual-modulus prescaler, built on a synchronous divide-by-4/5 core, divides the input by P or P+1. Two counters then decide which ratio applies. The swallow counter A keeps the modulus-control line high for the first A prescaler cycles of each output period, so the prescaler divides by P+1 there. The program counter B then closes the period after B prescaler cycles in total. The modulus P is 32 or 64, chosen by a select input.

The state machine has three states. ST_HOLD keeps everything at its load condition. ST_SWALLOW runs with modulus control high. ST_MAIN runs with modulus control low. The transitions are:
- ST_HOLD → ST_SWALLOW or ST_MAIN when the hold is released. The counters load, and the new state is ST_SWALLOW when the loaded A is non-zero.
- ST_SWALLOW → ST_MAIN on the prescaler tick that uses up the swallow count.
- ST_SWALLOW or ST_MAIN → reload at the tick that ends the period. This is the terminal count of B.
- Any running state → ST_HOLD while the hold or the restart strobe is asserted.

The configuration inputs are checked for legality. Legal values are taken over only when the state machine reloads, that is, at a period boundary or on release from hold. Illegal values are flagged and ignored.

Top module: `pulse_swallow_div`

## Requirements
- R1: Consecutive rising edges of `div_pulse_o` are N = B·P + A input cycles apart, with P = 32 when `psel_i` = 1 and P = 64 when `psel_i` = 0.
- R2: Within each output period, `mod_ctrl_o` is high for exactly A·(P+1) input cycles. These are the first A prescaler cycles of the period.
- R3: `div_pulse_o` is high for one prescaler cycle per period. That is the final cycle of the period: P input cycles wide, or P+1 when A equals B. It rises only after a prescaler tick.
- R4: A configuration with B < 3 or A > B sets `cfg_err_o` high one cycle after it is presented. While it is present, the divider keeps running with its previous legal values. The values in force always satisfy 3 ≤ B and A ≤ B.
- R5: New A, B or P values are taken over only at an output-period boundary. A period that is already running completes with the old ratio.
- R6: While `hold_i` (or `restart_i`) is high, both outputs are low from the next cycle onward, and the prescaler and counters are held at their load condition.
- R7: After a one-cycle `restart_i` strobe, the first rise of `div_pulse_o` comes N − L + 1 cycles after the strobe edge, where L is the final-cycle width from R3. This holds whatever the phase at which the strobe arrives.
- R8: During and directly after reset, `div_pulse_o`, `mod_ctrl_o` and `cfg_err_o` are low.
- R9: `mod_ctrl_o` falls only right after a prescaler tick or a hold. The 4/5 core therefore never sees a modulus change inside a prescaler cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Counter reset / power-down hold, active high |
| restart_i | input | 1 | Reference-aligned restart strobe |
| psel_i | input | 1 | Modulus select: 1 = 32/33, 0 = 64/65 |
| a_i | input | A_W (6) | Swallow count A |
| b_i | input | B_W (11) | Program count B |
| div_pulse_o | output | 1 | One pulse per N input cycles |
| mod_ctrl_o | output | 1 | Modulus control (high = divide by P+1) |
| cfg_err_o | output | 1 | Illegal A/B combination presented |

## Verification
The bench builds the block with its defaults: a 4/5 core followed by a 3-stage or 4-stage binary chain, which gives P = 32 or 64, a 6-bit A and an 11-bit B. These defaults bring both prescaler moduli within reach. They also allow small B values, which keep N in the hundreds of cycles, so many periods fit into a short run. They reach the corner cases as well: A = 0, A = B up to 63 (a swallow phase that fills the whole period), and illegal combinations with B below 3 or A above B. Restarts are applied at two unrelated phases of a running period to show that the first pulse after a restart lands at a fixed offset.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } ctl_state_t;

    localparam int CORE_W = 3;

endpackage

// File: rtl/pswl_cfg.sv
module pswl_cfg #(
    parameter int A_W     = 6,
    parameter int B_W     = 11,
    parameter int B_MIN   = 3,
    parameter int RST_A   = 0,
    parameter int RST_B   = 3,
    parameter bit RST_SEL = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adopt,
    input  logic           psel_in,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic           psel_act,
    output logic [A_W-1:0] a_act,
    output logic [B_W-1:0] b_act,
    output logic           psel_nxt,
    output logic [A_W-1:0] a_nxt,
    output logic [B_W-1:0] b_nxt,
    output logic           err
);

    logic legal;

    always_comb begin
        legal = (b_in >= B_W'(B_MIN)) && (B_W'(a_in) <= b_in);
        if (legal) begin
            psel_nxt = psel_in;
            a_nxt    = a_in;
            b_nxt    = b_in;
        end else begin
            psel_nxt = psel_act;
            a_nxt    = a_act;
            b_nxt    = b_act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_act <= RST_SEL;
            a_act    <= A_W'(RST_A);
            b_act    <= B_W'(RST_B);
            err      <= 1'b0;
        end else begin
            err <= !legal;
            if (adopt) begin
                psel_act <= psel_nxt;
                a_act    <= a_nxt;
                b_act    <= b_nxt;
            end
        end
    end

endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler
    import pswl_pkg::*;
#(
    parameter int STG_LO = 3,
    parameter int STG_HI = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic psel,
    input  logic mod_ctrl,
    output logic tick
);

    localparam int OW = (STG_HI > STG_LO) ? STG_HI : STG_LO;
    localparam logic [OW-1:0] LAST_LO = OW'((1 << STG_LO) - 1);
    localparam logic [OW-1:0] LAST_HI = OW'((1 << STG_HI) - 1);

    logic [CORE_W-1:0] core_q;
    logic [OW-1:0]     outer_q;
    logic [OW-1:0]     outer_last;
    logic              core5;
    logic              core_end;

    // the 4/5 core stretches to five only in the first outer step
    always_comb begin
        outer_last = psel ? LAST_LO : LAST_HI;
        core5      = mod_ctrl && (outer_q == '0);
        core_end   = core5 ? (core_q == CORE_W'(4)) : (core_q == CORE_W'(3));
        tick       = core_end && (outer_q == outer_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q  <= '0;
            outer_q <= '0;
        end else if (clear) begin
            core_q  <= '0;
            outer_q <= '0;
        end else if (core_end) begin
            core_q  <= '0;
            outer_q <= (outer_q == outer_last) ? '0 : outer_q + OW'(1);
        end else begin
            core_q  <= core_q + CORE_W'(1);
        end
    end

endmodule

// File: rtl/pswl_ctl.sv
module pswl_ctl
    import pswl_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           tick,
    input  logic [A_W-1:0] a_nxt,
    input  logic [B_W-1:0] b_nxt,
    output logic           mod_ctrl,
    output logic           pulse,
    output logic           adopt,
    output logic           pre_clear
);

    ctl_state_t     st_q, st_nxt;
    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;
    logic           last;
    logic           load;
    logic           step;

    assign last = (b_cnt == B_W'(1));

    // next state
    always_comb begin
        st_nxt = st_q;
        load   = 1'b0;
        step   = 1'b0;
        unique case (st_q)
            ST_HOLD: begin
                if (!hold) load = 1'b1;
            end
            ST_SWALLOW, ST_MAIN: begin
                if (hold) begin
                    st_nxt = ST_HOLD;
                end else if (tick) begin
                    if (last) load = 1'b1;
                    else      step = 1'b1;
                end
            end
            default: st_nxt = ST_HOLD;
        endcase
        if (load) begin
            st_nxt = (a_nxt != '0) ? ST_SWALLOW : ST_MAIN;
        end else if (step && (st_q == ST_SWALLOW) && (a_cnt == A_W'(1))) begin
            st_nxt = ST_MAIN;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_nxt;
    end

    // swallow and program counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cnt <= '0;
            b_cnt <= '0;
        end else if (load) begin
            a_cnt <= a_nxt;
            b_cnt <= b_nxt;
        end else if (step) begin
            b_cnt <= b_cnt - B_W'(1);
            if (st_q == ST_SWALLOW) a_cnt <= a_cnt - A_W'(1);
        end
    end

    // outputs
    always_comb begin
        mod_ctrl  = (st_q == ST_SWALLOW);
        pulse     = (st_q != ST_HOLD) && last;
        adopt     = load;
        pre_clear = hold || (st_q == ST_HOLD);
    end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int A_W    = 6,
    parameter int B_W    = 11,
    parameter int STG_LO = 3,
    parameter int STG_HI = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_i,
    input  logic           restart_i,
    input  logic           psel_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic           div_pulse_o,
    output logic           mod_ctrl_o,
    output logic           cfg_err_o
);

    logic           hold_eff;
    logic           adopt;
    logic           pre_clear;
    logic           pre_tick;
    logic           psel_act, psel_nxt;
    logic [A_W-1:0] a_act, a_nxt;
    logic [B_W-1:0] b_act, b_nxt;

    assign hold_eff = hold_i | restart_i;

    pswl_cfg #(.A_W(A_W), .B_W(B_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .adopt(adopt),
        .psel_in(psel_i), .a_in(a_i), .b_in(b_i),
        .psel_act(psel_act), .a_act(a_act), .b_act(b_act),
        .psel_nxt(psel_nxt), .a_nxt(a_nxt), .b_nxt(b_nxt),
        .err(cfg_err_o)
    );

    pswl_prescaler #(.STG_LO(STG_LO), .STG_HI(STG_HI)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(pre_clear),
        .psel(psel_act), .mod_ctrl(mod_ctrl_o), .tick(pre_tick)
    );

    pswl_ctl #(.A_W(A_W), .B_W(B_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .hold(hold_eff), .tick(pre_tick),
        .a_nxt(a_nxt), .b_nxt(b_nxt),
        .mod_ctrl(mod_ctrl_o), .pulse(div_pulse_o),
        .adopt(adopt), .pre_clear(pre_clear)
    );

endmodule

// File: rtl/pswl_chk.sv
module pswl_chk #(
    parameter int A_W = 6,
    parameter int B_W = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_eff,
    input logic           pre_tick,
    input logic           mod_ctrl_o,
    input logic           div_pulse_o,
    input logic           cfg_err_o,
    input logic [A_W-1:0] a_i,
    input logic [B_W-1:0] b_i,
    input logic [A_W-1:0] a_act,
    input logic [B_W-1:0] b_act
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_eff |=> (!mod_ctrl_o && !div_pulse_o));

    // R9
    mod_fall_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctrl_o) |-> ($past(pre_tick) || $past(hold_eff)));

    // R3
    pulse_rise_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_pulse_o) |-> $past(pre_tick));

    // R4
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cfg_err_o == (($past(b_i) < B_W'(3)) ||
                                   (B_W'($past(a_i)) > $past(b_i)))));

    // R4
    active_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_act >= B_W'(3)) && (B_W'(a_act) <= b_act));

endmodule

bind pulse_swallow_div pswl_chk #(.A_W(A_W), .B_W(B_W)) u_pswl_chk (
    .clk(clk), .rst_n(rst_n), .hold_eff(hold_eff), .pre_tick(pre_tick),
    .mod_ctrl_o(mod_ctrl_o), .div_pulse_o(div_pulse_o), .cfg_err_o(cfg_err_o),
    .a_i(a_i), .b_i(b_i), .a_act(a_act), .b_act(b_act)
);

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
module test_pulse_swallow_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_i = 1'b0;
    logic        restart_i = 1'b0;
    logic        psel_i = 1'b1;
    logic [5:0]  a_i = 6'd0;
    logic [10:0] b_i = 11'd3;
    logic        div_pulse_o, mod_ctrl_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pulse_swallow_div i_pulse_swallow_div (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .restart_i(restart_i),
        .psel_i(psel_i), .a_i(a_i), .b_i(b_i),
        .div_pulse_o(div_pulse_o), .mod_ctrl_o(mod_ctrl_o), .cfg_err_o(cfg_err_o)
    );

    // {psel, A, B}
    localparam int NV = 7;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 6'd0,  11'd3},
        {1'b1, 6'd5,  11'd7},
        {1'b0, 6'd2,  11'd3},
        {1'b1, 6'd10, 11'd10},
        {1'b0, 6'd0,  11'd4},
        {1'b1, 6'd63, 11'd63},
        {1'b0, 6'd1,  11'd5}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic s, input int a, input int b);
        psel_i = s;
        a_i    = 6'(a);
        b_i    = 11'(b);
    endtask

    task automatic wait_rise();
        logic p;
        p = div_pulse_o;
        forever begin
            @(negedge clk);
            if (div_pulse_o && !p) break;
            p = div_pulse_o;
        end
    endtask

    task automatic measure(output int per, output int md, output int pw);
        logic p;
        per = 0; md = 0; pw = 0;
        wait_rise();
        p = 1'b1;
        forever begin
            per++;
            md += int'(mod_ctrl_o);
            pw += int'(div_pulse_o);
            @(negedge clk);
            if (div_pulse_o && !p) break;
            p = div_pulse_o;
        end
    endtask

    function automatic int pval(input logic s);
        return s ? 32 : 64;
    endfunction

    function automatic int nval(input logic s, input int a, input int b);
        return b * pval(s) + a;
    endfunction

    function automatic int lval(input logic s, input int a, input int b);
        return (a == b) ? pval(s) + 1 : pval(s);
    endfunction

    task automatic do_restart(output int d);
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
        d = 0;
        while (!div_pulse_o) begin
            @(negedge clk);
            d++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int per, md, pw, n, d1, d2;

        // R8 reset state
        repeat (3) @(negedge clk);
        chk("R8 pulse in reset", int'(div_pulse_o), 0);
        chk("R8 mod in reset", int'(mod_ctrl_o), 0);
        chk("R8 err in reset", int'(cfg_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 pulse after reset", int'(div_pulse_o), 0);
        chk("R8 err after reset", int'(cfg_err_o), 0);

        // R1 R2 R3 vector table
        for (int i = 0; i < NV; i++) begin
            logic s;
            int a, b;
            s = VEC[i][17];
            a = int'(VEC[i][16:11]);
            b = int'(VEC[i][10:0]);
            set_cfg(s, a, b);
            measure(per, md, pw);
            measure(per, md, pw);
            measure(per, md, pw);
            chk("R1 period", per, nval(s, a, b));
            chk("R2 mod cycles", md, a * (pval(s) + 1));
            chk("R3 pulse width", pw, lval(s, a, b));
        end

        // R5 adoption at period boundary only
        set_cfg(1'b1, 5, 7);
        measure(per, md, pw);
        measure(per, md, pw);
        wait_rise();
        n = 0;
        begin
            logic p;
            p = 1'b1;
            forever begin
                n++;
                if (n == 40) set_cfg(1'b0, 2, 3);
                @(negedge clk);
                if (div_pulse_o && !p) break;
                p = div_pulse_o;
            end
        end
        chk("R5 running period keeps old ratio", n, nval(1'b1, 5, 7));
        measure(per, md, pw);
        measure(per, md, pw);
        chk("R5 new ratio after boundary", per, nval(1'b0, 2, 3));

        // R4 illegal B < 3
        set_cfg(1'b1, 0, 2);
        @(negedge clk);
        @(negedge clk);
        chk("R4 err for B below 3", int'(cfg_err_o), 1);
        measure(per, md, pw);
        measure(per, md, pw);
        chk("R4 ratio kept with B below 3", per, nval(1'b0, 2, 3));

        // R4 illegal A > B
        set_cfg(1'b1, 9, 5);
        @(negedge clk);
        @(negedge clk);
        chk("R4 err for A above B", int'(cfg_err_o), 1);
        measure(per, md, pw);
        measure(per, md, pw);
        chk("R4 ratio kept with A above B", per, nval(1'b0, 2, 3));

        set_cfg(1'b1, 5, 7);
        @(negedge clk);
        @(negedge clk);
        chk("R4 err clears on legal values", int'(cfg_err_o), 0);
        measure(per, md, pw);
        measure(per, md, pw);
        measure(per, md, pw);
        chk("R4 legal values adopted", per, nval(1'b1, 5, 7));

        // R6 hold keeps outputs low
        hold_i = 1'b1;
        @(negedge clk);
        begin
            int hits;
            hits = 0;
            for (int k = 0; k < 300; k++) begin
                hits += int'(div_pulse_o) + int'(mod_ctrl_o);
                @(negedge clk);
            end
            chk("R6 outputs low during hold", hits, 0);
        end
        hold_i = 1'b0;
        measure(per, md, pw);
        measure(per, md, pw);
        chk("R6 period after hold release", per, nval(1'b1, 5, 7));

        // R7 restart alignment at two phases
        wait_rise();
        repeat (17) @(negedge clk);
        do_restart(d1);
        chk("R7 restart offset phase one", d1,
            nval(1'b1, 5, 7) - lval(1'b1, 5, 7) + 1);
        repeat (101) @(negedge clk);
        do_restart(d2);
        chk("R7 restart offset phase two", d2, d1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule